// File: doc/BRIEF.md
# Indexed Configuration Register Window

This block implements a two-byte I/O window through which a host reaches 256 internal byte-wide configuration registers. The lower (even) address of the window is a pointer port: a byte written there chooses which internal register later accesses reach. The upper (odd) address is the value port: a write there stores the byte into the chosen register, and a read there returns the chosen register's contents. All accesses are single bytes.

Most of the 256 registers are read-only and always read as zero. A small, irregular set of indices in the upper part of the space is writable, and six of those come out of reset with fixed nonzero values. Two of the writable registers hold base-address codes for two serial channels. This block does not move those channels. When software writes any code other than the reset code, the block raises a sticky flag so that the surrounding logic can detect the unsupported request. The whole window only responds while an external enable input is high. That input is driven from bit 1 of a control byte in the host bridge's configuration space. Read data is registered and appears one clock after the read strobe.

Top module: `cfg_window_port`

## Requirements
- R1: After synchronous reset, the pointer is 0x00, `reloc_flag` is 0, `io_rdata` is 0xFF, and the registers hold these values: index 0xE0 = 0x3C, 0xE2 = 0x03, 0xE3 = 0xFC, 0xE6 = 0xDE, 0xE7 = 0xFE, 0xE8 = 0xBE, and every other index = 0x00.
- R2: While enabled, a write to the pointer port (address `BASE_ADDR`, which is 0x3F0 by default) loads `io_wdata` into the pointer. A read of the pointer port returns the pointer value.
- R3: While enabled, a write to the value port (address `BASE_ADDR`+1, which is 0x3F1 by default) stores `io_wdata` into the register selected by the pointer if that index is writable. A later read of the value port returns the stored byte.
- R4: The following indices are read-only and always read as 0x00, and writes to them have no effect: 0x00–0xDF, 0xE4, 0xE5, 0xE9–0xED, 0xF3, 0xF5, 0xF7, 0xF9–0xFB and 0xFD–0xFF. The writable indices are 0xE0–0xE3, 0xE6–0xE8, 0xEE–0xF2, 0xF4, 0xF6, 0xF8 and 0xFC.
- R5: Writing index 0xE7 with a value other than 0xFE, or index 0xE8 with a value other than 0xBE, sets `reloc_flag`, and the register still takes the written value. Writing the reset value leaves the flag unchanged. Once set, the flag stays set until reset.
- R6: `io_hit` is high, in the same cycle, exactly when `cfg_enable` is 1, a read or write strobe is active, and `io_addr` falls inside the two-byte window.
- R7: While `cfg_enable` is 0, writes to either port change nothing, and a read returns 0xFF.
- R8: Accesses to addresses outside the window change nothing, and a read there returns 0xFF.
- R9: `io_rdata` is loaded on the clock edge that samples `io_rd`, so it is valid in the following cycle. It holds that value until the next read strobe, and writes do not change it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| io_addr | input | ADDR_W (16) | I/O address of the current access |
| io_wr | input | 1 | Write strobe, one byte per cycle |
| io_rd | input | 1 | Read strobe |
| io_wdata | input | 8 | Write data |
| io_rdata | output | 8 | Registered read data, valid one clock after `io_rd` |
| io_hit | output | 1 | Decode hit for the current access |
| cfg_enable | input | 1 | Window enable, driven from bit 1 of the host-side control byte |
| reloc_flag | output | 1 | Sticky flag: a serial base-code register was written with a non-default code |

## Verification
The bench targets the edges of the read-only map. It writes 0x10, 0xE4, 0xF3 and 0xFF, each of which must read back zero, and it writes the isolated writable holes 0xF4 and 0xFC, which must read back the data. A protection decode that is off by one, or that treats ranges as single points, either keeps data it should drop or loses data it should keep. The relocation flag is checked in several ways: it must not rise when the default code is written back, it must rise from either register, it must stay set, and the register must still take the value. A design that blocks that write, or that clears the flag, fails a read-back or a flag check. The bench also performs disabled and out-of-window accesses, then re-reads the pointer and the selected register to show nothing moved. It checks that `io_rdata` holds through idle cycles and data writes, which catches a transparent or write-sensitive read path.

// File: rtl/cfg_window_pkg.sv
package cfg_window_pkg;

    localparam int IDX_W    = 8;
    localparam int DATA_W   = 8;
    localparam int NUM_REGS = 1 << IDX_W;

    typedef logic [IDX_W-1:0]  idx_t;
    typedef logic [DATA_W-1:0] byte_t;

    localparam byte_t OPEN_BUS = '1;

    typedef enum logic [1:0] {
        PORT_NONE  = 2'd0,
        PORT_INDEX = 2'd1,
        PORT_DATA  = 2'd2
    } port_sel_e;

    typedef struct packed {
        logic      wr;
        logic      rd;
        port_sel_e port;
        byte_t     wdata;
    } io_req_t;

    // Read-only (always zero) indices of the register space.
    function automatic logic is_locked(input int idx);
        return (idx <= 'hDF) ||
               (idx >= 'hFD) ||
               (idx >= 'hE9 && idx <= 'hED) ||
               (idx >= 'hF9 && idx <= 'hFB) ||
               (idx == 'hE4) || (idx == 'hE5) ||
               (idx == 'hF3) || (idx == 'hF5) || (idx == 'hF7);
    endfunction

    function automatic byte_t reset_val(input int idx);
        case (idx)
            'hE0:    return 8'h3C;
            'hE2:    return 8'h03;
            'hE3:    return 8'hFC;
            'hE6:    return 8'hDE;
            'hE7:    return 8'hFE;
            'hE8:    return 8'hBE;
            default: return 8'h00;
        endcase
    endfunction

    // Serial base-address code registers.
    function automatic logic is_reloc_idx(input int idx);
        return (idx == 'hE7) || (idx == 'hE8);
    endfunction

endpackage

// File: rtl/cfg_addr_decode.sv
module cfg_addr_decode
    import cfg_window_pkg::*;
#(
    parameter int                ADDR_W    = 16,
    parameter logic [ADDR_W-1:0] BASE_ADDR = 'h3F0
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr,
    input  logic              rd,
    input  byte_t             wdata,
    input  logic              enable,
    output io_req_t           req,
    output logic              hit
);

    logic in_window;

    always_comb begin
        in_window = (addr[ADDR_W-1:1] == BASE_ADDR[ADDR_W-1:1]);
        hit       = enable && in_window && (wr || rd);
        req.wr    = hit && wr;
        req.rd    = rd;
        req.wdata = wdata;
        if (!hit)         req.port = PORT_NONE;
        else if (addr[0]) req.port = PORT_DATA;
        else              req.port = PORT_INDEX;
    end

endmodule

// File: rtl/cfg_index_reg.sv
module cfg_index_reg
    import cfg_window_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  load,
    input  byte_t wdata,
    output idx_t  idx
);

    always_ff @(posedge clk) begin
        if (rst)       idx <= '0;
        else if (load) idx <= idx_t'(wdata);
    end

    a_r2_index_load: assert property (@(posedge clk) disable iff (rst)
        load |=> (idx == idx_t'($past(wdata))));

    a_r2_index_hold: assert property (@(posedge clk) disable iff (rst)
        !load |=> $stable(idx));

endmodule

// File: rtl/cfg_reg_file.sv
module cfg_reg_file
    import cfg_window_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  idx_t  idx,
    input  logic  wr_en,
    input  byte_t wdata,
    output byte_t rd_byte,
    output logic  reloc_flag
);

    byte_t regs [NUM_REGS];

    for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
        if (is_locked(i)) begin : g_ro
            assign regs[i] = '0;
        end else begin : g_rw
            always_ff @(posedge clk) begin
                if (rst)
                    regs[i] <= reset_val(i);
                else if (wr_en && (int'(idx) == i))
                    regs[i] <= wdata;
            end
        end
    end

    assign rd_byte = regs[idx];

    logic reloc_hit;
    assign reloc_hit = wr_en && is_reloc_idx(int'(idx)) &&
                       (wdata != reset_val(int'(idx)));

    always_ff @(posedge clk) begin
        if (rst)            reloc_flag <= 1'b0;
        else if (reloc_hit) reloc_flag <= 1'b1;
    end

    a_r3_write_lands: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !is_locked(int'(idx))) |=> (rd_byte == $past(wdata)));

    a_r4_locked_zero: assert property (@(posedge clk) disable iff (rst)
        (wr_en && is_locked(int'(idx))) |=> (rd_byte == '0));

    a_r5_flag_sets: assert property (@(posedge clk) disable iff (rst)
        (wr_en && is_reloc_idx(int'(idx)) &&
         (wdata != reset_val(int'(idx)))) |=> reloc_flag);

    a_r5_flag_sticky: assert property (@(posedge clk) disable iff (rst)
        reloc_flag |=> reloc_flag);

endmodule

// File: rtl/cfg_window_port.sv
module cfg_window_port
    import cfg_window_pkg::*;
#(
    parameter int                ADDR_W    = 16,
    parameter logic [ADDR_W-1:0] BASE_ADDR = 'h3F0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] io_addr,
    input  logic              io_wr,
    input  logic              io_rd,
    input  logic [7:0]        io_wdata,
    output logic [7:0]        io_rdata,
    output logic              io_hit,
    input  logic              cfg_enable,
    output logic              reloc_flag
);

    io_req_t req;
    idx_t    idx;
    byte_t   file_byte;
    byte_t   rdata_q;

    cfg_addr_decode #(
        .ADDR_W    (ADDR_W),
        .BASE_ADDR (BASE_ADDR)
    ) u_decode (
        .addr   (io_addr),
        .wr     (io_wr),
        .rd     (io_rd),
        .wdata  (io_wdata),
        .enable (cfg_enable),
        .req    (req),
        .hit    (io_hit)
    );

    cfg_index_reg u_index (
        .clk   (clk),
        .rst   (rst),
        .load  (req.wr && (req.port == PORT_INDEX)),
        .wdata (req.wdata),
        .idx   (idx)
    );

    cfg_reg_file u_file (
        .clk        (clk),
        .rst        (rst),
        .idx        (idx),
        .wr_en      (req.wr && (req.port == PORT_DATA)),
        .wdata      (req.wdata),
        .rd_byte    (file_byte),
        .reloc_flag (reloc_flag)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata_q <= OPEN_BUS;
        end else if (req.rd) begin
            case (req.port)
                PORT_DATA:  rdata_q <= file_byte;
                PORT_INDEX: rdata_q <= byte_t'(idx);
                default:    rdata_q <= OPEN_BUS;
            endcase
        end
    end

    assign io_rdata = rdata_q;

    a_r6_hit_gated: assert property (@(posedge clk) disable iff (rst)
        io_hit |-> (cfg_enable && (io_wr || io_rd)));

    a_r7_disabled_read: assert property (@(posedge clk) disable iff (rst)
        (io_rd && !cfg_enable) |=> (io_rdata == 8'hFF));

    a_r8_outside_read: assert property (@(posedge clk) disable iff (rst)
        (io_rd && (io_addr[ADDR_W-1:1] != BASE_ADDR[ADDR_W-1:1]))
            |=> (io_rdata == 8'hFF));

    a_r9_rdata_hold: assert property (@(posedge clk) disable iff (rst)
        !io_rd |=> $stable(io_rdata));

endmodule

// File: tb/sim_cfg_window_port.sv
`timescale 1ns/1ps
module sim_cfg_window_port;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] io_addr = '0;
    logic        io_wr = 1'b0;
    logic        io_rd = 1'b0;
    logic [7:0]  io_wdata = '0;
    logic [7:0]  io_rdata;
    logic        io_hit;
    logic        cfg_enable = 1'b1;
    logic        reloc_flag;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    cfg_window_port u0 (
        .clk        (clk),
        .rst        (rst),
        .io_addr    (io_addr),
        .io_wr      (io_wr),
        .io_rd      (io_rd),
        .io_wdata   (io_wdata),
        .io_rdata   (io_rdata),
        .io_hit     (io_hit),
        .cfg_enable (cfg_enable),
        .reloc_flag (reloc_flag)
    );

    localparam logic [15:0] P_IDX = 16'h03F0;
    localparam logic [15:0] P_DAT = 16'h03F1;

    // Vector fields: {req[3:0], is_read, addr[15:0], byte[7:0]}.
    // For a write the byte is the data; for a read it is the expected value.
    localparam int NV = 24;
    localparam logic [28:0] VEC [NV] = '{
        {4'd2, 1'b0, P_IDX, 8'hE1},  // R2 select writable 0xE1
        {4'd3, 1'b0, P_DAT, 8'h5A},  // R3
        {4'd3, 1'b1, P_DAT, 8'h5A},  // R3 read back
        {4'd2, 1'b1, P_IDX, 8'hE1},  // R2 pointer read
        {4'd2, 1'b0, P_IDX, 8'h10},  // R4 locked low range
        {4'd4, 1'b0, P_DAT, 8'h77},
        {4'd4, 1'b1, P_DAT, 8'h00},
        {4'd2, 1'b0, P_IDX, 8'hE4},  // R4 locked single
        {4'd4, 1'b0, P_DAT, 8'h11},
        {4'd4, 1'b1, P_DAT, 8'h00},
        {4'd2, 1'b0, P_IDX, 8'hFF},  // R4 locked top
        {4'd4, 1'b0, P_DAT, 8'h22},
        {4'd4, 1'b1, P_DAT, 8'h00},
        {4'd2, 1'b0, P_IDX, 8'hFC},  // R3 isolated writable
        {4'd3, 1'b0, P_DAT, 8'hA5},
        {4'd3, 1'b1, P_DAT, 8'hA5},
        {4'd2, 1'b0, P_IDX, 8'hF3},  // R4 isolated locked
        {4'd4, 1'b0, P_DAT, 8'h99},
        {4'd4, 1'b1, P_DAT, 8'h00},
        {4'd2, 1'b0, P_IDX, 8'hF4},  // R3 isolated writable
        {4'd3, 1'b0, P_DAT, 8'h66},
        {4'd3, 1'b1, P_DAT, 8'h66},
        {4'd2, 1'b0, P_IDX, 8'hE0},  // R3 overwrite reset value
        {4'd3, 1'b0, P_DAT, 8'hC3}
    };

    task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic wr(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        io_addr = a; io_wdata = d; io_wr = 1'b1;
        @(negedge clk);
        io_wr = 1'b0;
    endtask

    task automatic rd(input logic [15:0] a, output logic [7:0] q);
        @(negedge clk);
        io_addr = a; io_rd = 1'b1;
        @(negedge clk);
        io_rd = 1'b0;
        q = io_rdata;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic read_reg(input logic [7:0] i, output logic [7:0] q);
        wr(P_IDX, i);
        rd(P_DAT, q);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [7:0] q;
        do_reset();

        // R1 reset state
        check("R1 rdata", io_rdata, 8'hFF);
        check("R1 hit", {7'd0, io_hit}, 8'h00);
        check("R1 flag", {7'd0, reloc_flag}, 8'h00);
        rd(P_IDX, q);       check("R1 pointer", q, 8'h00);
        rd(P_DAT, q);       check("R1 idx00", q, 8'h00);
        read_reg(8'hE0, q); check("R1 E0", q, 8'h3C);
        read_reg(8'hE1, q); check("R1 E1", q, 8'h00);
        read_reg(8'hE2, q); check("R1 E2", q, 8'h03);
        read_reg(8'hE3, q); check("R1 E3", q, 8'hFC);
        read_reg(8'hE6, q); check("R1 E6", q, 8'hDE);
        read_reg(8'hE7, q); check("R1 E7", q, 8'hFE);
        read_reg(8'hE8, q); check("R1 E8", q, 8'hBE);
        read_reg(8'hEE, q); check("R1 EE", q, 8'h00);

        // Table walk (R2, R3, R4)
        for (int k = 0; k < NV; k++) begin
            if (VEC[k][24]) begin
                rd(VEC[k][23:8], q);
                check($sformatf("R%0d vec%0d", VEC[k][28:25], k), q, VEC[k][7:0]);
            end else begin
                wr(VEC[k][23:8], VEC[k][7:0]);
            end
        end
        rd(P_DAT, q); check("R3 E0 overwritten", q, 8'hC3);

        // R6 hit timing
        @(negedge clk);
        io_addr = P_DAT; io_rd = 1'b1; #1;
        check("R6 hit on access", {7'd0, io_hit}, 8'h01);
        @(negedge clk);
        io_rd = 1'b0; #1;
        check("R6 no hit idle", {7'd0, io_hit}, 8'h00);

        // R5 relocation flag
        wr(P_IDX, 8'hE7);
        wr(P_DAT, 8'hFE);
        check("R5 default code no flag", {7'd0, reloc_flag}, 8'h00);
        wr(P_DAT, 8'h12);
        check("R5 flag set E7", {7'd0, reloc_flag}, 8'h01);
        rd(P_DAT, q); check("R5 E7 takes value", q, 8'h12);
        wr(P_IDX, 8'hE8);
        wr(P_DAT, 8'hBE);
        check("R5 flag sticky", {7'd0, reloc_flag}, 8'h01);
        do_reset();
        check("R1 flag cleared by reset", {7'd0, reloc_flag}, 8'h00);
        read_reg(8'hE7, q); check("R1 E7 restored", q, 8'hFE);
        wr(P_IDX, 8'hE8);
        wr(P_DAT, 8'h00);
        check("R5 flag set E8", {7'd0, reloc_flag}, 8'h01);

        // R7 disabled window
        wr(P_IDX, 8'hF0);
        wr(P_DAT, 8'h44);
        cfg_enable = 1'b0;
        @(negedge clk);
        io_addr = P_DAT; io_wdata = 8'h55; io_wr = 1'b1; #1;
        check("R6 no hit when disabled", {7'd0, io_hit}, 8'h00);
        @(negedge clk);
        io_wr = 1'b0;
        wr(P_IDX, 8'hE0);
        rd(P_DAT, q); check("R7 disabled read", q, 8'hFF);
        cfg_enable = 1'b1;
        rd(P_IDX, q); check("R7 pointer unchanged", q, 8'hF0);
        rd(P_DAT, q); check("R7 data unchanged", q, 8'h44);

        // R8 outside the window
        wr(16'h03F2, 8'hF1);
        wr(16'h02F1, 8'h99);
        rd(P_IDX, q); check("R8 pointer unchanged", q, 8'hF0);
        rd(P_DAT, q); check("R8 data unchanged", q, 8'h44);
        rd(16'h03F2, q); check("R8 outside read", q, 8'hFF);

        // R9 read data hold
        rd(P_DAT, q);
        repeat (3) @(negedge clk);
        check("R9 hold idle", io_rdata, 8'h44);
        wr(P_DAT, 8'h88);
        check("R9 hold across write", io_rdata, 8'h44);
        rd(P_DAT, q); check("R9 new read", q, 8'h88);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule